// File: doc/BRIEF.md
# Memory Bank Command State Tracker

This block follows the state of each internal bank of a double-data-rate synchronous memory and rules on every command a controller issues. Each cycle it takes one command (activate, read, write, precharge, auto refresh, self-refresh entry or self-refresh exit) with a bank index and an auto-precharge flag. In the same cycle it returns a verdict: accepted or illegal. Only accepted commands change the tracked state.

Each bank is either idle or open. A read or write flagged for auto-precharge arms a per-bank countdown of half the burst length in clocks. When the countdown ends the bank closes by itself. A write starts a shared write window of the same length, and a read that arrives inside it is refused. Refresh commands need every bank idle. While the device is in self refresh, only the exit command is accepted.

Top module: `bank_cmd_tracker`

## Requirements
- R1: While reset is asserted, and after it is released, every bank is idle, no auto-precharge is pending, `self_refresh` and `write_burst` are low, and a no-operation command yields neither verdict.
- R2: An activate to an idle bank is accepted and `bank_open` of that bank rises at the next clock edge. An activate to an open bank is illegal.
- R3: A read or write to an idle bank is illegal.
- R4: An accepted read or write with `cmd_ap` high sets `ap_pending` of its bank at the next edge. The bank then closes N clock edges after the command edge, and its pending bit clears on that same edge. N is half the burst length: `burst_code` 0 gives BL2 (N=1), 1 gives BL4 (N=2), 2 gives BL8 (N=4), and the reserved value 3 behaves as BL8.
- R5: A read, write or precharge to a bank whose auto-precharge is pending is illegal.
- R6: An accepted write raises `write_burst` for N cycles, where N is set by `burst_code` as in R4. A read presented while `write_burst` is high is illegal. A later write reloads the window.
- R7: A precharge to an open bank is accepted and closes it at the next edge. A precharge to an idle bank is accepted and changes nothing.
- R8: Auto refresh and self-refresh entry are accepted only when all banks are idle. An accepted entry raises `self_refresh` at the next edge.
- R9: While `self_refresh` is high, every command other than exit is illegal. An exit is accepted and clears `self_refresh`. An exit outside self refresh is illegal.
- R10: An illegal command changes no bank, pending, window or self-refresh state.
- R11: Command code 0 is a no-operation: both `cmd_accept` and `cmd_illegal` stay low. Codes are 1 activate, 2 read, 3 write, 4 precharge, 5 auto refresh, 6 self-refresh entry, 7 self-refresh exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_op | input | 3 | Command code (see R11) |
| cmd_bank | input | 2 | Target bank index |
| cmd_ap | input | 1 | Auto-precharge flag for read or write |
| burst_code | input | 2 | Burst length selection (see R4) |
| cmd_accept | output | 1 | Current command is legal and takes effect |
| cmd_illegal | output | 1 | Current command is refused |
| bank_open | output | 4 | Per-bank open state |
| ap_pending | output | 4 | Per-bank self-timed precharge armed |
| self_refresh | output | 1 | Device is in self refresh |
| write_burst | output | 1 | A write burst is in progress |

## Verification
The assertions assume that `cmd_op` and `cmd_bank` are known values every cycle and that `cmd_bank` names one of the four banks. They also assume that `burst_code` holds one of its four codes. The stimulus drives every input at the falling edge from fixed values, so no X reaches the block after reset, and it never uses a bank index outside the range. Illegal commands are sent on purpose, because the assertions only relate accepted commands to later state and never forbid the controller from issuing a refused command.

// File: rtl/bst_pkg.sv
package bst_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_REF = 3'd5,
    OP_SRE = 3'd6,
    OP_SRX = 3'd7
  } bst_op_e;

  // longest burst in clocks (BL8 -> 4)
  localparam int unsigned BURST_CLK_MAX = 4;
  localparam int unsigned TMR_W         = $clog2(BURST_CLK_MAX + 1);

  function automatic logic [TMR_W-1:0] burst_clocks(input logic [1:0] code);
    case (code)
      2'd0:    return TMR_W'(1);
      2'd1:    return TMR_W'(2);
      default: return TMR_W'(BURST_CLK_MAX);
    endcase
  endfunction

endpackage

// File: rtl/bst_bank_slot.sv
module bst_bank_slot
  import bst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_req,
  input  logic             close_req,
  input  logic             ap_req,
  input  logic [TMR_W-1:0] ap_len,
  output logic             is_open,
  output logic             ap_pend
);

  logic             open_q, open_d;
  logic             pend_q, pend_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             en;

  assign en = open_req | close_req | ap_req | pend_q;

  always_comb begin
    open_d = open_q;
    pend_d = pend_q;
    tmr_d  = tmr_q;
    if (pend_q) begin
      tmr_d = tmr_q - TMR_W'(1);
      if (tmr_q == TMR_W'(1)) begin
        open_d = 1'b0;
        pend_d = 1'b0;
      end
    end
    if (open_req)  open_d = 1'b1;
    if (close_req) open_d = 1'b0;
    if (ap_req) begin
      pend_d = 1'b1;
      tmr_d  = ap_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      pend_q <= 1'b0;
      tmr_q  <= '0;
    end else if (en) begin
      open_q <= open_d;
      pend_q <= pend_d;
      tmr_q  <= tmr_d;
    end
  end

  assign is_open = open_q;
  assign ap_pend = pend_q;

  // R4: a pending self-timed precharge always belongs to an open bank
  p_pend_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> open_q);

  // R4: the last countdown cycle closes the bank
  p_ap_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && tmr_q == TMR_W'(1) && !open_req) |=> !open_q);

  // R3: the command checker only arms auto-precharge on an open bank
  p_ap_on_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ap_req |-> open_q);

  // R2: the command checker only requests opening an idle bank
  p_open_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    open_req |-> !open_q);

endmodule

// File: rtl/bst_write_window.sv
module bst_write_window
  import bst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_start,
  input  logic [TMR_W-1:0] wr_len,
  output logic             busy
);

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             en;

  assign en = wr_start | (tmr_q != '0);

  always_comb begin
    if (wr_start)          tmr_d = wr_len;
    else if (tmr_q != '0)  tmr_d = tmr_q - TMR_W'(1);
    else                   tmr_d = tmr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  tmr_q <= '0;
    else if (en) tmr_q <= tmr_d;
  end

  assign busy = (tmr_q != '0);

  // R6: without a new write the window only shrinks, one clock at a time
  p_window_drains_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_start) |=> (tmr_q == TMR_W'($past(tmr_q) - TMR_W'(1))));

  // R6: a write always opens the window
  p_write_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> busy);

endmodule

// File: rtl/bst_sr_ctl.sv
module bst_sr_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic leave,
  output logic in_sr
);

  logic sr_q, sr_d;
  logic en;

  assign en = enter | leave;

  always_comb begin
    sr_d = sr_q;
    if (enter) sr_d = 1'b1;
    if (leave) sr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sr_q <= 1'b0;
    else if (en) sr_q <= sr_d;
  end

  assign in_sr = sr_q;

  // R9: exit is only granted from self refresh
  p_leave_in_sr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    leave |-> sr_q);

  // R8: entry is only granted outside self refresh
  p_enter_out_sr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    enter |-> !sr_q);

endmodule

// File: rtl/bst_cmd_check.sv
module bst_cmd_check
  import bst_pkg::*;
#(
  parameter int unsigned NB = 4,
  parameter int unsigned BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bst_op_e       op,
  input  logic [BW-1:0] bank,
  input  logic          ap,
  input  logic [NB-1:0] bank_open,
  input  logic [NB-1:0] bank_pend,
  input  logic          in_sr,
  input  logic          wr_busy,
  output logic          accept,
  output logic          illegal,
  output logic [NB-1:0] open_req,
  output logic [NB-1:0] close_req,
  output logic [NB-1:0] ap_req,
  output logic          wr_start,
  output logic          sr_enter,
  output logic          sr_leave
);

  logic tgt_open, tgt_pend, all_idle, ok, is_cmd;

  assign tgt_open = bank_open[bank];
  assign tgt_pend = bank_pend[bank];
  assign all_idle = ~|bank_open;
  assign is_cmd   = (op != OP_NOP);

  always_comb begin
    ok = 1'b0;
    case (op)
      OP_ACT:         ok = !in_sr && !tgt_open;
      OP_RD:          ok = !in_sr && tgt_open && !tgt_pend && !wr_busy;
      OP_WR:          ok = !in_sr && tgt_open && !tgt_pend;
      OP_PRE:         ok = !in_sr && !tgt_pend;
      OP_REF, OP_SRE: ok = !in_sr && all_idle;
      OP_SRX:         ok = in_sr;
      default:        ok = 1'b0;
    endcase
  end

  assign accept  = is_cmd && ok;
  assign illegal = is_cmd && !ok;

  for (genvar b = 0; b < NB; b++) begin : g_strobe
    logic sel;
    assign sel          = (bank == BW'(b));
    assign open_req[b]  = accept && sel && (op == OP_ACT);
    assign close_req[b] = accept && sel && (op == OP_PRE);
    assign ap_req[b]    = accept && sel && ap && (op == OP_RD || op == OP_WR);
  end

  assign wr_start = accept && (op == OP_WR);
  assign sr_enter = accept && (op == OP_SRE);
  assign sr_leave = accept && (op == OP_SRX);

  // R9: in self refresh the only command let through is the exit
  p_sr_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sr && accept) |-> (op == OP_SRX));

  // R5: no read, write or precharge accepted on a bank with a pending precharge
  p_pend_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && tgt_pend) |-> !(op == OP_RD || op == OP_WR || op == OP_PRE));

endmodule

// File: rtl/bank_cmd_tracker.sv
module bank_cmd_tracker
  import bst_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cmd_op,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic                 cmd_ap,
  input  logic [1:0]           burst_code,
  output logic                 cmd_accept,
  output logic                 cmd_illegal,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [NUM_BANKS-1:0] ap_pending,
  output logic                 self_refresh,
  output logic                 write_burst
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  bst_op_e              op;
  logic [TMR_W-1:0]     blen;
  logic [NUM_BANKS-1:0] open_req, close_req, ap_req;
  logic                 wr_start, sr_enter, sr_leave;

  assign op   = bst_op_e'(cmd_op);
  assign blen = burst_clocks(burst_code);

  bst_cmd_check #(.NB(NUM_BANKS), .BW(BANK_W)) i_check (
    .clk       (clk),
    .rst_n     (rst_q),
    .op        (op),
    .bank      (cmd_bank),
    .ap        (cmd_ap),
    .bank_open (bank_open),
    .bank_pend (ap_pending),
    .in_sr     (self_refresh),
    .wr_busy   (write_burst),
    .accept    (cmd_accept),
    .illegal   (cmd_illegal),
    .open_req  (open_req),
    .close_req (close_req),
    .ap_req    (ap_req),
    .wr_start  (wr_start),
    .sr_enter  (sr_enter),
    .sr_leave  (sr_leave)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bst_bank_slot i_slot (
      .clk       (clk),
      .rst_n     (rst_q),
      .open_req  (open_req[b]),
      .close_req (close_req[b]),
      .ap_req    (ap_req[b]),
      .ap_len    (blen),
      .is_open   (bank_open[b]),
      .ap_pend   (ap_pending[b])
    );
  end

  bst_write_window i_wwin (
    .clk      (clk),
    .rst_n    (rst_q),
    .wr_start (wr_start),
    .wr_len   (blen),
    .busy     (write_burst)
  );

  bst_sr_ctl i_sr (
    .clk   (clk),
    .rst_n (rst_q),
    .enter (sr_enter),
    .leave (sr_leave),
    .in_sr (self_refresh)
  );

  // R8: self refresh never coexists with an open bank
  p_sr_all_idle_r8: assert property (@(posedge clk) disable iff (!rst_q)
    self_refresh |-> (bank_open == '0));

  // R2: an accepted activate opens its bank on the next edge
  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd_accept && op == OP_ACT) |=> bank_open[$past(cmd_bank)]);

  // R6: no read accepted inside a write burst
  p_read_gate_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd_accept && op == OP_RD) |-> !write_burst);

  // R10: a refused command leaves the self-refresh state alone
  p_illegal_holds_r10: assert property (@(posedge clk) disable iff (!rst_q)
    cmd_illegal |=> $stable(self_refresh));

  // R11: the two verdicts never coincide
  p_verdict_excl_r11: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({cmd_accept, cmd_illegal}));

endmodule

// File: tb/test_bank_cmd_tracker.sv
module test_bank_cmd_tracker;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cmd_op;
  logic [1:0] cmd_bank;
  logic       cmd_ap;
  logic [1:0] burst_code;
  logic       cmd_accept, cmd_illegal;
  logic [3:0] bank_open, ap_pending;
  logic       self_refresh, write_burst;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  bank_cmd_tracker i_bank_cmd_tracker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_op       (cmd_op),
    .cmd_bank     (cmd_bank),
    .cmd_ap       (cmd_ap),
    .burst_code   (burst_code),
    .cmd_accept   (cmd_accept),
    .cmd_illegal  (cmd_illegal),
    .bank_open    (bank_open),
    .ap_pending   (ap_pending),
    .self_refresh (self_refresh),
    .write_burst  (write_burst)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [1:0] bk, input logic ap, input logic [1:0] bc);
    cmd_op = op; cmd_bank = bk; cmd_ap = ap; burst_code = bc;
  endtask

  // {req, op, bank, ap, burst, accept, illegal, open, pend, sr, wburst}
  // ops: 0 NOP 1 ACT 2 RD 3 WR 4 PRE 5 REF 6 SRE 7 SRX
  localparam int NV = 32;
  localparam logic [23:0] VEC [NV] = '{
    {4'd2, 3'd1,2'd0,1'b0,2'd0, 1'b1,1'b0, 4'b0001,4'b0000,1'b0,1'b0}, // R2 act b0
    {4'd2, 3'd1,2'd0,1'b0,2'd0, 1'b0,1'b1, 4'b0001,4'b0000,1'b0,1'b0}, // R2 act open b0
    {4'd3, 3'd2,2'd1,1'b0,2'd0, 1'b0,1'b1, 4'b0001,4'b0000,1'b0,1'b0}, // R3 rd idle
    {4'd3, 3'd3,2'd1,1'b0,2'd0, 1'b0,1'b1, 4'b0001,4'b0000,1'b0,1'b0}, // R3 wr idle
    {4'd2, 3'd1,2'd2,1'b0,2'd0, 1'b1,1'b0, 4'b0101,4'b0000,1'b0,1'b0}, // R2 act b2
    {4'd6, 3'd3,2'd0,1'b0,2'd1, 1'b1,1'b0, 4'b0101,4'b0000,1'b0,1'b1}, // R6 wr BL4
    {4'd6, 3'd2,2'd2,1'b0,2'd1, 1'b0,1'b1, 4'b0101,4'b0000,1'b0,1'b1}, // R6 rd in window
    {4'd6, 3'd2,2'd2,1'b0,2'd1, 1'b0,1'b1, 4'b0101,4'b0000,1'b0,1'b0}, // R6 rd last cycle
    {4'd4, 3'd2,2'd2,1'b1,2'd1, 1'b1,1'b0, 4'b0101,4'b0100,1'b0,1'b0}, // R4 rd ap BL4
    {4'd5, 3'd3,2'd2,1'b0,2'd1, 1'b0,1'b1, 4'b0101,4'b0100,1'b0,1'b0}, // R5 wr pending
    {4'd4, 3'd0,2'd0,1'b0,2'd0, 1'b0,1'b0, 4'b0001,4'b0000,1'b0,1'b0}, // R4 close
    {4'd8, 3'd5,2'd0,1'b0,2'd0, 1'b0,1'b1, 4'b0001,4'b0000,1'b0,1'b0}, // R8 ref busy
    {4'd7, 3'd4,2'd0,1'b0,2'd0, 1'b1,1'b0, 4'b0000,4'b0000,1'b0,1'b0}, // R7 pre open
    {4'd7, 3'd4,2'd3,1'b0,2'd0, 1'b1,1'b0, 4'b0000,4'b0000,1'b0,1'b0}, // R7 pre idle
    {4'd8, 3'd5,2'd0,1'b0,2'd0, 1'b1,1'b0, 4'b0000,4'b0000,1'b0,1'b0}, // R8 ref
    {4'd8, 3'd6,2'd0,1'b0,2'd0, 1'b1,1'b0, 4'b0000,4'b0000,1'b1,1'b0}, // R8 enter
    {4'd9, 3'd1,2'd1,1'b0,2'd0, 1'b0,1'b1, 4'b0000,4'b0000,1'b1,1'b0}, // R9 act in sr
    {4'd9, 3'd5,2'd0,1'b0,2'd0, 1'b0,1'b1, 4'b0000,4'b0000,1'b1,1'b0}, // R9 ref in sr
    {4'd9, 3'd7,2'd0,1'b0,2'd0, 1'b1,1'b0, 4'b0000,4'b0000,1'b0,1'b0}, // R9 exit
    {4'd9, 3'd7,2'd0,1'b0,2'd0, 1'b0,1'b1, 4'b0000,4'b0000,1'b0,1'b0}, // R9 exit outside
    {4'd2, 3'd1,2'd3,1'b0,2'd0, 1'b1,1'b0, 4'b1000,4'b0000,1'b0,1'b0}, // R2 act b3
    {4'd8, 3'd6,2'd0,1'b0,2'd0, 1'b0,1'b1, 4'b1000,4'b0000,1'b0,1'b0}, // R8 enter busy
    {4'd4, 3'd3,2'd3,1'b1,2'd0, 1'b1,1'b0, 4'b1000,4'b1000,1'b0,1'b1}, // R4 wr ap BL2
    {4'd4, 3'd0,2'd0,1'b0,2'd0, 1'b0,1'b0, 4'b0000,4'b0000,1'b0,1'b0}, // R4 closed
    {4'd2, 3'd1,2'd1,1'b0,2'd0, 1'b1,1'b0, 4'b0010,4'b0000,1'b0,1'b0}, // R2 act b1
    {4'd4, 3'd2,2'd1,1'b1,2'd2, 1'b1,1'b0, 4'b0010,4'b0010,1'b0,1'b0}, // R4 rd ap BL8
    {4'd4, 3'd0,2'd0,1'b0,2'd0, 1'b0,1'b0, 4'b0010,4'b0010,1'b0,1'b0}, // R4
    {4'd4, 3'd0,2'd0,1'b0,2'd0, 1'b0,1'b0, 4'b0010,4'b0010,1'b0,1'b0}, // R4
    {4'd5, 3'd4,2'd1,1'b0,2'd0, 1'b0,1'b1, 4'b0010,4'b0010,1'b0,1'b0}, // R5 pre pending
    {4'd4, 3'd0,2'd0,1'b0,2'd0, 1'b0,1'b0, 4'b0000,4'b0000,1'b0,1'b0}, // R4 closes
    {4'd2, 3'd1,2'd1,1'b0,2'd0, 1'b1,1'b0, 4'b0010,4'b0000,1'b0,1'b0}, // R2 reopen
    {4'd4, 3'd2,2'd1,1'b1,2'd3, 1'b1,1'b0, 4'b0010,4'b0010,1'b0,1'b0}  // R4 reserved code
  };

  task automatic chk_state(input string req, input logic [3:0] o, input logic [3:0] p,
                           input logic s, input logic w);
    chk(req, "bank_open",    int'(bank_open),    int'(o));
    chk(req, "ap_pending",   int'(ap_pending),   int'(p));
    chk(req, "self_refresh", int'(self_refresh), int'(s));
    chk(req, "write_burst",  int'(write_burst),  int'(w));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(3'd0, 2'd0, 1'b0, 2'd0);
    repeat (3) @(negedge clk);
    chk_state("R1", 4'b0000, 4'b0000, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_state("R1", 4'b0000, 4'b0000, 1'b0, 1'b0);
    chk("R1", "nop verdict", int'({cmd_accept, cmd_illegal}), 0);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      string       rq, rs;
      v  = VEC[i];
      rq = (v[19:17] == 3'd0) ? "R11" : $sformatf("R%0d", v[23:20]);
      rs = v[10] ? "R10" : $sformatf("R%0d", v[23:20]);
      drive(v[19:17], v[16:15], v[14], v[13:12]);
      #1;
      chk(rq, $sformatf("row %0d accept", i),  int'(cmd_accept),  int'(v[11]));
      chk(rq, $sformatf("row %0d illegal", i), int'(cmd_illegal), int'(v[10]));
      @(negedge clk);
      chk_state(rs, v[9:6], v[5:2], v[1], v[0]);
    end

    // R1: reset in the middle of a pending precharge clears everything
    drive(3'd0, 2'd0, 1'b0, 2'd0);
    rst_n = 1'b0;
    #1;
    chk_state("R1", 4'b0000, 4'b0000, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6: window reload by a second write, then the read boundary
    drive(3'd1, 2'd0, 1'b0, 2'd0);
    @(negedge clk);
    drive(3'd3, 2'd0, 1'b0, 2'd2);   // BL8 write, window 4
    @(negedge clk);
    drive(3'd3, 2'd0, 1'b0, 2'd1);   // BL4 write reloads window to 2
    @(negedge clk);
    drive(3'd2, 2'd0, 1'b0, 2'd0);
    #1 chk("R6", "read inside reloaded window", int'(cmd_illegal), 1);
    @(negedge clk);
    #1 chk("R6", "read at window end", int'(cmd_illegal), 1);
    @(negedge clk);
    #1 chk("R6", "read after window", int'(cmd_accept), 1);
    chk("R6", "window closed", int'(write_burst), 0);
    @(negedge clk);
    drive(3'd0, 2'd0, 1'b0, 2'd0);
    chk_state("R7", 4'b0001, 4'b0000, 1'b0, 1'b0);

    finish_run();
  end

endmodule